// File: doc/BRIEF.md
# Serial Pattern Generator and Bit Error Checker

This block exercises a serial link one bit at a time. A bit-enable input marks the cycles in which one bit is produced and one bit is received. The transmit side sends one of two maximal-length pseudo-random sequences, or a user word of programmable length repeated endlessly. On command it corrupts traffic by inverting one bit. It can also invert one bit in every 10^n bits.

The receive side needs no phase or seed from the transmit side. While it searches, it predicts each bit from the bits it has received and waits for a run of correct predictions. Once locked, it runs its own copy of the pattern. An inverted bit then counts as exactly one error. A burst of errors drops the lock and the search starts again.

Two saturating counters run on the receive side. One counts received bits and the other counts errors seen while locked. A latch strobe copies both counts to the output registers and starts a new measurement interval.

Top module: `bert_core`

## Requirements
- R1: With pattern select 0, every transmitted bit b[k] equals b[k-15] XOR b[k-14] (polynomial x^15+x^14+1).
- R2: With pattern select 1, every transmitted bit b[k] equals b[k-23] XOR b[k-18] (polynomial x^23+x^18+1).
- R3: With pattern select 2 or 3, the word input is sent least significant bit first and repeats with a period of length-field + 1 bits (1 to 32). Any full period carries as many ones as the used bits of the word.
- R4: The lock flag rises after 32 consecutive correctly predicted bits. While locked, an error-free stream adds no errors.
- R5: Bit errors are counted only while locked. A stream that matches no pattern, such as alternating ones and zeros under select 0, never produces lock and never adds errors.
- R6: While locked, 6 errors within one 64-bit window clear the lock, and the search starts again.
- R7: A single-error request flips exactly one bit, the first enabled bit at or after the request, and the checker counts exactly one error.
- R8: With a nonzero rate exponent n (1..7), one bit in every 10^n enabled bits is flipped; the first flip falls on the 10^n-th bit. An exponent of 0 disables rate insertion.
- R9: Reset clears the transmit bit, the lock flag and both latched counts. A latch strobe publishes both counts and restarts them in the same cycle. A bit enabled in the strobe cycle belongs to the new interval. The latched outputs change only after a strobe.
- R10: Both counters stop at their all-ones value instead of wrapping.
- R11: The transmitted bit changes only after a cycle with the bit enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One bit sent and one received in this cycle |
| pat_sel | input | 2 | 0: 15-stage sequence, 1: 23-stage sequence, 2/3: repeating word |
| rep_word | input | WORD_W | Repeating word, bit 0 sent first |
| rep_len | input | LEN_W | Word length minus one |
| inj_single | input | 1 | Request to flip one transmitted bit |
| rate_exp | input | 3 | Error rate exponent n, 0 = off |
| tx_bit | output | 1 | Transmitted bit (registered) |
| rx_bit | input | 1 | Received bit, sampled when bit_en is high |
| latch | input | 1 | Publish counts and start a new interval |
| sync | output | 1 | Checker locked to the incoming pattern |
| bit_cnt_q | output | CNT_W | Latched received-bit count |
| err_cnt_q | output | CNT_W | Latched error count |

## Verification
The stimulus runs in loopback with both sequences and with two word lengths, a short odd one and the full 32 bits. The transmit stream is checked against its recurrence or period, and lock must follow in each case. An alternating stream fed from outside tests that a search cannot be fooled and that no errors are counted while unlocked. Single requests, with and without a coincident enable, are checked against rate insertion at exponents 1 and 2. Exponent 1 must break lock through the loss window, while exponent 2 keeps it and yields an exact error count. Latched counts over known bit totals, including an overflow run and a strobe coincident with an enable, separate the saturation and interval-boundary behaviour.

// File: rtl/bert_pkg.sv
package bert_pkg;

   typedef enum logic [1:0] {
      PAT_PRBS15 = 2'd0,
      PAT_PRBS23 = 2'd1,
      PAT_WORD   = 2'd2,
      PAT_WORD_B = 2'd3
   } pat_e;

   localparam int HIST_W = 32;

   // Predicted next bit from the last HIST_W bits (bit 0 = most recent).
   function automatic logic next_bit(input logic [HIST_W-1:0] h,
                                     input pat_e              sel,
                                     input logic [4:0]        last);
      case (sel)
         PAT_PRBS15: return h[14] ^ h[13];
         PAT_PRBS23: return h[22] ^ h[17];
         default:    return h[last];
      endcase
   endfunction

   // True when the active shift window is all zero (generator lock-up guard).
   function automatic logic prbs_zero(input logic [HIST_W-1:0] h, input pat_e sel);
      if (sel == PAT_PRBS15) return (h[14:0] == 15'd0);
      return (h[22:0] == 23'd0);
   endfunction

endpackage

// File: rtl/bert_patgen.sv
module bert_patgen
   import bert_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int LEN_W   = 5,
   parameter int MAX_EXP = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  pat_e              sel,
   input  logic [WORD_W-1:0] rep_word,
   input  logic [LEN_W-1:0]  rep_len,
   input  logic              inj_single,
   input  logic [2:0]        rate_exp,
   output logic              tx_bit
);
   localparam int RATE_W = $clog2(10 ** MAX_EXP);

   if (WORD_W < 2 || WORD_W > HIST_W || (1 << LEN_W) != WORD_W)
      $error("bert_patgen: WORD_W must be a power of two within 2..32");
   if (MAX_EXP < 1 || MAX_EXP > 7)
      $error("bert_patgen: MAX_EXP must be 1..7");

   function automatic logic [RATE_W-1:0] period_last(input logic [2:0] n);
      logic [RATE_W:0] p;
      p = 1;
      for (int i = 0; i < MAX_EXP; i++)
         if (i < int'(n)) p = p * 4'd10;
      return RATE_W'(p - 1'b1);
   endfunction

   logic [HIST_W-1:0] hist;
   logic [LEN_W-1:0]  idx;
   logic              pend;
   logic [RATE_W-1:0] rcnt, rlast;
   logic              is_prbs, pat_bit, rate_hit, flip;

   always_comb begin
      is_prbs  = (sel == PAT_PRBS15) || (sel == PAT_PRBS23);
      rlast    = period_last(rate_exp);
      rate_hit = (rate_exp != 3'd0) && (rcnt >= rlast);
      pat_bit  = is_prbs ? (next_bit(hist, sel, 5'd0) | prbs_zero(hist, sel))
                         : rep_word[idx];
      flip     = pend | inj_single | rate_hit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist   <= '1;
         idx    <= '0;
         pend   <= 1'b0;
         rcnt   <= '0;
         tx_bit <= 1'b0;
      end else begin
         if (rate_exp == 3'd0)
            rcnt <= '0;
         else if (bit_en)
            rcnt <= rate_hit ? '0 : rcnt + 1'b1;

         if (bit_en) begin
            tx_bit <= pat_bit ^ flip;
            pend   <= 1'b0;
            idx    <= (idx >= rep_len) ? '0 : idx + 1'b1;
            if (is_prbs) hist <= {hist[HIST_W-2:0], pat_bit};
         end else if (inj_single) begin
            pend <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/bert_sync_chk.sv
module bert_sync_chk
   import bert_pkg::*;
#(
   parameter int LEN_W    = 5,
   parameter int SYNC_RUN = 32,
   parameter int LOSS_WIN = 64,
   parameter int LOSS_ERR = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             rx_bit,
   input  pat_e             sel,
   input  logic [LEN_W-1:0] rep_len,
   output logic             in_sync,
   output logic             err_hit
);
   localparam int RUN_W = $clog2(SYNC_RUN);
   localparam int WIN_W = $clog2(LOSS_WIN);
   localparam int ERR_W = $clog2(LOSS_ERR);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(SYNC_RUN - 1);
   localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(LOSS_WIN - 1);
   localparam logic [ERR_W-1:0] ERR_LAST = ERR_W'(LOSS_ERR - 1);

   if (SYNC_RUN < 2 || LOSS_WIN < 2 || LOSS_ERR < 2 || LOSS_ERR > LOSS_WIN)
      $error("bert_sync_chk: bad lock parameters");

   logic [HIST_W-1:0] hist;
   logic [RUN_W-1:0]  run;
   logic [WIN_W-1:0]  wcnt;
   logic [ERR_W-1:0]  werr;
   logic              pred, match;

   always_comb begin
      pred    = next_bit(hist, sel, 5'(rep_len));
      match   = (rx_bit == pred);
      err_hit = bit_en & in_sync & ~match;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist    <= '0;
         run     <= '0;
         wcnt    <= '0;
         werr    <= '0;
         in_sync <= 1'b0;
      end else if (bit_en) begin
         if (!in_sync) begin
            // search: prediction is seeded from the received stream
            hist <= {hist[HIST_W-2:0], rx_bit};
            if (!match)
               run <= '0;
            else if (run == RUN_LAST) begin
               in_sync <= 1'b1;
               run     <= '0;
               wcnt    <= '0;
               werr    <= '0;
            end else
               run <= run + 1'b1;
         end else begin
            // locked: local pattern runs free
            hist <= {hist[HIST_W-2:0], pred};
            if (!match && werr == ERR_LAST) begin
               in_sync <= 1'b0;
               run     <= '0;
            end else if (wcnt == WIN_LAST) begin
               wcnt <= '0;
               werr <= '0;
            end else begin
               wcnt <= wcnt + 1'b1;
               werr <= werr + {{(ERR_W-1){1'b0}}, ~match};
            end
         end
      end
   end

endmodule

// File: rtl/bert_sat_cnt.sv
module bert_sat_cnt #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         latch,
   output logic [W-1:0] q
);
   if (W < 2) $error("bert_sat_cnt: W must be at least 2");

   localparam logic [W-1:0] TOP = '1;

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         q   <= '0;
      end else if (latch) begin
         q   <= cnt;
         cnt <= {{(W-1){1'b0}}, inc};
      end else if (inc && cnt != TOP) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/bert_core.sv
module bert_core
   import bert_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int CNT_W    = 32,
   parameter int MAX_EXP  = 7,
   parameter int SYNC_RUN = 32,
   parameter int LOSS_WIN = 64,
   parameter int LOSS_ERR = 6,
   localparam int LEN_W   = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [1:0]        pat_sel,
   input  logic [WORD_W-1:0] rep_word,
   input  logic [LEN_W-1:0]  rep_len,
   input  logic              inj_single,
   input  logic [2:0]        rate_exp,
   output logic              tx_bit,
   input  logic              rx_bit,
   input  logic              latch,
   output logic              sync,
   output logic [CNT_W-1:0]  bit_cnt_q,
   output logic [CNT_W-1:0]  err_cnt_q
);
   pat_e             sel;
   logic             err_hit;
   logic [1:0]       inc_v;
   logic [CNT_W-1:0] q_v [2];

   assign sel   = pat_e'(pat_sel);
   assign inc_v = {err_hit, bit_en};

   bert_patgen #(.WORD_W(WORD_W), .LEN_W(LEN_W), .MAX_EXP(MAX_EXP)) u_gen (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sel(sel),
      .rep_word(rep_word), .rep_len(rep_len), .inj_single(inj_single),
      .rate_exp(rate_exp), .tx_bit(tx_bit)
   );

   bert_sync_chk #(.LEN_W(LEN_W), .SYNC_RUN(SYNC_RUN),
                   .LOSS_WIN(LOSS_WIN), .LOSS_ERR(LOSS_ERR)) u_chk (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
      .sel(sel), .rep_len(rep_len), .in_sync(sync), .err_hit(err_hit)
   );

   for (genvar g = 0; g < 2; g++) begin : g_cnt
      bert_sat_cnt #(.W(CNT_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .inc(inc_v[g]), .latch(latch), .q(q_v[g])
      );
   end

   assign bit_cnt_q = q_v[0];
   assign err_cnt_q = q_v[1];

endmodule

// File: rtl/bert_sva.sv
module bert_sva #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_en,
   input logic             latch,
   input logic             tx_bit,
   input logic             sync,
   input logic [CNT_W-1:0] bit_cnt_q,
   input logic [CNT_W-1:0] err_cnt_q
);
   assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(tx_bit));

   assert_lock_on_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync) |-> $past(bit_en));

   assert_unlock_on_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync) |-> $past(bit_en));

   assert_counts_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !latch |=> ($stable(bit_cnt_q) && $stable(err_cnt_q)));

   assert_err_le_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      err_cnt_q <= bit_cnt_q);

endmodule

bind bert_core bert_sva #(.CNT_W(CNT_W)) u_bert_sva (
   .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .latch(latch),
   .tx_bit(tx_bit), .sync(sync), .bit_cnt_q(bit_cnt_q), .err_cnt_q(err_cnt_q)
);

// File: tb/bert_core_bench.sv
`timescale 1ns/1ps
module bert_core_bench;
   localparam int CW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bit_en = 1'b0;
   logic [1:0]    pat_sel = 2'd0;
   logic [31:0]   rep_word = 32'd0;
   logic [4:0]    rep_len = 5'd0;
   logic          inj_single = 1'b0;
   logic [2:0]    rate_exp = 3'd0;
   logic          tx_bit;
   logic          rx_bit;
   logic          latch = 1'b0;
   logic          sync;
   logic [CW-1:0] bit_cnt_q, err_cnt_q;

   logic          loop = 1'b1;
   logic          rx_drv = 1'b0;
   assign rx_bit = loop ? tx_bit : rx_drv;

   bert_core #(.CNT_W(CW)) u_bert_core (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pat_sel(pat_sel),
      .rep_word(rep_word), .rep_len(rep_len), .inj_single(inj_single),
      .rate_exp(rate_exp), .tx_bit(tx_bit), .rx_bit(rx_bit), .latch(latch),
      .sync(sync), .bit_cnt_q(bit_cnt_q), .err_cnt_q(err_cnt_q)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // transmit trace: kind 0 off, 1 15-stage, 2 23-stage, 3 period per
   logic [31:0] hb = 32'd0;
   int kind = 0, per = 1, nrec = 0, mism = 0;
   int nb, ne;

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic trace(input int k, input int p);
      kind = k; per = p; nrec = 0; mism = 0;
   endtask

   task automatic cyc(input logic en, input logic inj, input logic lat);
      logic e;
      int   win;
      bit_en = en; inj_single = inj; latch = lat;
      if (en && !loop) rx_drv = ~rx_drv;
      @(negedge clk);
      if (en) begin
         case (kind)
            1: begin e = hb[14] ^ hb[13]; win = 15; end
            2: begin e = hb[22] ^ hb[17]; win = 23; end
            default: begin e = hb[per-1]; win = per; end
         endcase
         if (kind != 0 && nrec >= win && tx_bit !== e) mism++;
         hb = {hb[30:0], tx_bit};
         nrec++;
      end
      bit_en = 1'b0; inj_single = 1'b0; latch = 1'b0;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0);
   endtask

   task automatic grab(input logic en);
      cyc(en, 1'b0, 1'b1);
      nb = int'(bit_cnt_q);
      ne = int'(err_cnt_q);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic hold;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      chk("R9 reset tx", tx_bit, 0);
      chk("R9 reset sync", sync, 0);
      chk("R9 reset bit count", bit_cnt_q, 0);
      chk("R9 reset err count", err_cnt_q, 0);

      // R1 + R4: 15-stage sequence in loopback
      trace(1, 1);
      run(150);
      chk("R1 recurrence mismatches", mism, 0);
      chk("R4 lock 15-stage", sync, 1);
      trace(0, 1);
      grab(1'b0); run(200); grab(1'b0);
      chk("R4 clean bits", nb, 200);
      chk("R4 clean errors", ne, 0);

      // R11: no enable, no change
      hold = tx_bit;
      for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b0);
      chk("R11 tx held", tx_bit, hold);

      // R7: single request with and without coincident enable
      grab(1'b0); run(20); cyc(1'b1, 1'b1, 1'b0); run(20); grab(1'b0);
      chk("R7 coincident bits", nb, 41);
      chk("R7 coincident errors", ne, 1);
      grab(1'b0); cyc(1'b0, 1'b1, 1'b0); run(30); grab(1'b0);
      chk("R7 pending bits", nb, 30);
      chk("R7 pending errors", ne, 1);

      // R8: exponent 2, one flip per 100 bits, lock kept
      rate_exp = 3'd2;
      grab(1'b0); run(1005); rate_exp = 3'd0; grab(1'b0);
      chk("R8 rate bits", nb, 1005);
      chk("R8 rate errors", ne, 10);
      chk("R8 lock kept", sync, 1);

      // R6: exponent 1 breaks lock; R5: no counting while unlocked
      rate_exp = 3'd1;
      run(150);
      chk("R6 lock lost", sync, 0);
      grab(1'b0); run(50); grab(1'b0);
      chk("R5 unlocked bits", nb, 50);
      chk("R5 unlocked errors", ne, 0);
      rate_exp = 3'd0;
      run(100);
      chk("R4 relock", sync, 1);

      // R5: alternating stream never locks
      loop = 1'b0;
      run(100);
      chk("R6 lock lost on garbage", sync, 0);
      grab(1'b0); run(200); grab(1'b0);
      chk("R5 garbage sync", sync, 0);
      chk("R5 garbage errors", ne, 0);
      chk("R5 garbage bits", nb, 200);
      loop = 1'b1;

      // R2: 23-stage sequence
      pat_sel = 2'd1;
      trace(2, 1);
      run(200);
      chk("R2 recurrence mismatches", mism, 0);
      chk("R2 lock 23-stage", sync, 1);
      trace(0, 1);
      grab(1'b0); run(100); grab(1'b0);
      chk("R2 clean errors", ne, 0);

      // R3: 13-bit word
      pat_sel = 2'd2; rep_word = 32'h0000_1A5B; rep_len = 5'd12;
      trace(3, 13);
      run(250);
      chk("R3 period 13 mismatches", mism, 0);
      chk("R3 ones per period 13", $countones(hb[12:0]), 8);
      chk("R3 lock word", sync, 1);
      trace(0, 1);
      grab(1'b0); cyc(1'b1, 1'b1, 1'b0); run(40); grab(1'b0);
      chk("R7 word errors", ne, 1);
      chk("R7 word bits", nb, 41);

      // R3: full 32-bit word on select 3
      pat_sel = 2'd3; rep_word = 32'hF0A5_3C01; rep_len = 5'd31;
      trace(3, 32);
      run(300);
      chk("R3 period 32 mismatches", mism, 0);
      chk("R3 ones per period 32", $countones(hb), 13);
      chk("R3 lock full word", sync, 1);
      trace(0, 1);

      // R10: saturation
      grab(1'b0); run(1100); grab(1'b0);
      chk("R10 saturated bits", nb, 1023);
      chk("R10 errors clean", ne, 0);

      // R9: strobe with an enabled bit starts the new interval with it
      grab(1'b1); run(9); grab(1'b0);
      chk("R9 boundary bits", nb, 10);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule